// File: doc/BRIEF.md
# Multicore Reset and Boot Sequencer

This block is a 32-bit register window that lets software reset the cores of a small processor cluster and start or stop its secondary core. Each core has its own request/done handshake. A write that changes a core's reset bit sends that core a one-cycle reset request. The reset bit stays set in the register until the core answers with done, and then the block clears it by itself. A write that changes the secondary core's enable bit sends a start request or a power-off request. A start request carries an entry address and an argument, both taken from two general-purpose registers at the moment of the write.

Every core has its own sequencer with three states: `SQ_IDLE`, `SQ_ISSUE` and `SQ_WAIT`.
- **launch** (`SQ_IDLE`→`SQ_ISSUE`): taken on a trigger. The request is asserted for the single cycle spent in `SQ_ISSUE`.
- **arm** (`SQ_ISSUE`→`SQ_WAIT`): always taken on the next cycle.
- **finish** (`SQ_WAIT`→`SQ_IDLE`): taken when done arrives and nothing is held.
- **relaunch** (`SQ_WAIT`→`SQ_ISSUE`): taken when done arrives while a newer trigger is held, or arrives in the same cycle.

A trigger that arrives while a request is outstanding is kept in a single hold slot. Only the newest held trigger is kept. All other registers are plain storage.

Top module: `corectl_top`

## Requirements
- R1: After reset, every register reads zero except three. Offset 0x00 reads 0xA0, offset 0x1C reads 0x1 and offset 0x24 reads 0x1F.
- R2: The register index is `bus_addr[11:2]`. Indices 0..19 (offsets 0x00..0x4C) store written words and read them back, including general-purpose registers 1..10 at 0x28..0x4C.
- R3: A read at any offset from 0x50 to 0xFFC returns zero. A write to that range changes no register.
- R4: Consider a write to 0x04. For each core i in {0,1}, if bit i of the written word differs from the stored bit i, then `core_req[i]` is high in the cycle after the write with `core_op` slice equal to 1 (reset). If bit i does not differ, no request is sent. `core_op` is 0 whenever the request is low.
- R5: A write to 0x04 stores the written word. Reset bit i of 0x04 then stays at its written value until `core_done[i]` is sampled high while core i's request is outstanding. In that cycle the bit clears. A write in the same cycle wins over the clear.
- R6: Consider a write to 0x08 that changes bit 1 from 0 to 1. Core 1 then gets a request with op 2 (start). `boot_entry` and `boot_arg` carry the values that offsets 0x30 and 0x34 held at the time of the write. A write to 0x08 that leaves bit 1 unchanged sends no request and is stored.
- R7: A write to 0x08 that changes bit 1 from 1 to 0 sends core 1 a request with op 3 (power-off).
- R8: Completion of a start or power-off request also clears bit 1 of 0x04.
- R9: A trigger that arrives while a core's request is outstanding is held, not issued. It is issued in the cycle after that core's done. Only the most recent held trigger is kept.
- R10: `core_done[i]` has no effect on any core other than i. It also has no effect when core i has no request outstanding.
- R11: Each request is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte offset in the 4 KiB window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| core_req | output | NCORE | One-cycle request per core |
| core_op | output | 2*NCORE | Request kind per core: 1 reset, 2 start, 3 power-off |
| core_done | input | NCORE | Per-core completion |
| boot_entry | output | 32 | Entry address for a start request |
| boot_arg | output | 32 | Argument for a start request |

## Verification
The bench sweeps every reset-bit pattern written over a cleared register. A design that compares against zero instead of against the stored value would issue requests for unchanged bits. A design that clears the bit on write instead of on done would read back too early. Writes are pushed in while a request is outstanding, so that a missing hold slot, or one that keeps the oldest trigger, shows up as lost or wrong-kind requests. Done is also pulsed on the wrong core to catch a cross-wired clear, and a start or power-off completion must clear the core 1 reset bit.

// File: rtl/corectl_pkg.sv
package corectl_pkg;

    localparam int IX_CTRL  = 0;
    localparam int IX_CRST  = 1;
    localparam int IX_CPWR  = 2;
    localparam int IX_STAT  = 7;
    localparam int IX_IMASK = 9;
    localparam int IX_GPR1  = 10;
    localparam int IX_ENTRY = IX_GPR1 + 2;
    localparam int IX_ARG   = IX_GPR1 + 3;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_RESET = 2'd1,
        OP_START = 2'd2,
        OP_OFF   = 2'd3
    } core_op_e;

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_ISSUE = 2'd1,
        SQ_WAIT  = 2'd2
    } seq_state_e;

    function automatic logic [31:0] reg_init(input int idx);
        case (idx)
            IX_CTRL:  return 32'h0000_00A0;
            IX_STAT:  return 32'h0000_0001;
            IX_IMASK: return 32'h0000_001F;
            default:  return 32'h0;
        endcase
    endfunction

endpackage

// File: rtl/corectl_core_seq.sv
module corectl_core_seq
    import corectl_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     trig,
    input  core_op_e trig_op,
    input  logic     done,
    output logic     req,
    output core_op_e op,
    output logic     clr
);

    seq_state_e state_q, state_d;
    core_op_e   cur_op_q;
    logic       held_v_q;
    core_op_e   held_op_q;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE:  if (trig) state_d = SQ_ISSUE;
            SQ_ISSUE: state_d = SQ_WAIT;
            SQ_WAIT:  if (done) state_d = (trig || held_v_q) ? SQ_ISSUE : SQ_IDLE;
            default:  state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_d;
    end

    // operation and hold slot
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_op_q  <= OP_NONE;
            held_v_q  <= 1'b0;
            held_op_q <= OP_NONE;
        end else begin
            unique case (state_q)
                SQ_IDLE: if (trig) cur_op_q <= trig_op;
                SQ_ISSUE: if (trig) begin
                    held_v_q  <= 1'b1;
                    held_op_q <= trig_op;
                end
                SQ_WAIT: begin
                    if (done) begin
                        held_v_q <= 1'b0;
                        if (trig)          cur_op_q <= trig_op;
                        else if (held_v_q) cur_op_q <= held_op_q;
                    end else if (trig) begin
                        held_v_q  <= 1'b1;
                        held_op_q <= trig_op;
                    end
                end
                default: held_v_q <= 1'b0;
            endcase
        end
    end

    // outputs
    always_comb begin
        req = (state_q == SQ_ISSUE);
        op  = req ? cur_op_q : OP_NONE;
        clr = (state_q == SQ_WAIT) && done;
    end

endmodule

// File: rtl/corectl_store.sv
module corectl_store
    import corectl_pkg::*;
#(
    parameter int NREG  = 20,
    parameter int NCORE = 2,
    localparam int RW   = $clog2(NREG)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [RW-1:0]         widx,
    input  logic [31:0]           wdata,
    input  logic [NCORE-1:0]      clr_mask,
    output logic [NREG-1:0][31:0] regs
);

    logic [31:0] clr_word;
    assign clr_word = {{(32-NCORE){1'b0}}, clr_mask};

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        if (g == IX_CRST) begin : g_selfclr
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                      regs[g] <= reg_init(g);
                else if (we && widx == RW'(g))   regs[g] <= wdata;
                else                             regs[g] <= regs[g] & ~clr_word;
            end
        end else begin : g_plain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                      regs[g] <= reg_init(g);
                else if (we && widx == RW'(g))   regs[g] <= wdata;
            end
        end
    end

endmodule

// File: rtl/corectl_top.sv
module corectl_top
    import corectl_pkg::*;
#(
    parameter int NCORE    = 2,
    parameter int NGPR     = 10,
    parameter int AW       = 12,
    parameter int SEC_CORE = 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [AW-1:0]        bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          bus_rdata,
    output logic [NCORE-1:0]     core_req,
    output logic [2*NCORE-1:0]   core_op,
    input  logic [NCORE-1:0]     core_done,
    output logic [31:0]          boot_entry,
    output logic [31:0]          boot_arg
);

    localparam int NREG = IX_GPR1 + NGPR;
    localparam int IW   = AW - 2;
    localparam int RW   = $clog2(NREG);

    logic [IW-1:0]         idx;
    logic [RW-1:0]         ridx;
    logic                  in_range, wr_ok, crst_wr, cpwr_wr, boot_trig;
    logic                  addr_lo_unused;
    logic [NCORE-1:0]      clr_mask;
    logic [NREG-1:0][31:0] regs;

    assign idx            = bus_addr[AW-1:2];
    assign addr_lo_unused = ^bus_addr[1:0];
    assign in_range       = idx < IW'(NREG);
    assign ridx           = idx[RW-1:0];
    assign wr_ok          = bus_sel && bus_wr && in_range;
    assign crst_wr        = wr_ok && (ridx == RW'(IX_CRST));
    assign cpwr_wr        = wr_ok && (ridx == RW'(IX_CPWR));
    assign bus_rdata      = (bus_sel && in_range) ? regs[ridx] : 32'h0;

    corectl_store #(.NREG(NREG), .NCORE(NCORE)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (wr_ok),
        .widx     (ridx),
        .wdata    (bus_wdata),
        .clr_mask (clr_mask),
        .regs     (regs)
    );

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        logic     rst_trig, pwr_trig;
        core_op_e t_op, s_op;

        assign rst_trig = crst_wr && (regs[IX_CRST][c] ^ bus_wdata[c]);
        if (c == SEC_CORE) begin : g_pwr
            assign pwr_trig = cpwr_wr && (regs[IX_CPWR][c] ^ bus_wdata[c]);
        end else begin : g_nopwr
            assign pwr_trig = 1'b0;
        end
        assign t_op = pwr_trig ? (bus_wdata[c] ? OP_START : OP_OFF) : OP_RESET;

        corectl_core_seq u_seq (
            .clk     (clk),
            .rst_n   (rst_n),
            .trig    (rst_trig || pwr_trig),
            .trig_op (t_op),
            .done    (core_done[c]),
            .req     (core_req[c]),
            .op      (s_op),
            .clr     (clr_mask[c])
        );
        assign core_op[2*c +: 2] = s_op;
    end

    assign boot_trig = cpwr_wr && (regs[IX_CPWR][SEC_CORE] ^ bus_wdata[SEC_CORE])
                       && bus_wdata[SEC_CORE];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            boot_entry <= 32'h0;
            boot_arg   <= 32'h0;
        end else if (boot_trig) begin
            boot_entry <= regs[IX_ENTRY];
            boot_arg   <= regs[IX_ARG];
        end
    end

endmodule

// File: rtl/corectl_chk.sv
module corectl_chk
    import corectl_pkg::*;
#(
    parameter int NCORE    = 2,
    parameter int AW       = 12,
    parameter int NREG     = 20,
    parameter int SEC_CORE = 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic [AW-1:0]      bus_addr,
    input logic [31:0]        bus_rdata,
    input logic [NCORE-1:0]   core_req,
    input logic [2*NCORE-1:0] core_op,
    input logic [NCORE-1:0]   core_done,
    input logic [NCORE-1:0]   crst
);

    logic [AW-3:0] cidx;
    logic          crst_write;
    assign cidx       = bus_addr[AW-1:2];
    assign crst_write = bus_sel && bus_wr && (cidx == (AW-2)'(IX_CRST));

    assert_oob_read_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && cidx >= (AW-2)'(NREG)) |-> bus_rdata == 32'h0);

    for (genvar c = 0; c < NCORE; c++) begin : g_chk
        assert_req_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
            core_req[c] |=> !core_req[c]);

        assert_idle_op_R4: assert property (@(posedge clk) disable iff (!rst_n)
            !core_req[c] |-> core_op[2*c +: 2] == OP_NONE);

        if (c == SEC_CORE) begin : g_sec
            assert_req_op_R4: assert property (@(posedge clk) disable iff (!rst_n)
                core_req[c] |-> core_op[2*c +: 2] != OP_NONE);
        end else begin : g_oth
            assert_reset_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
                core_req[c] |-> core_op[2*c +: 2] == OP_RESET);
        end

        assert_selfclear_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(crst[c]) |-> ($past(core_done[c]) || $past(crst_write)));
    end

endmodule

bind corectl_top corectl_chk #(
    .NCORE(NCORE), .AW(AW), .NREG(NREG), .SEC_CORE(SEC_CORE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .core_req  (core_req),
    .core_op   (core_op),
    .core_done (core_done),
    .crst      (regs[corectl_pkg::IX_CRST][NCORE-1:0])
);

// File: tb/corectl_top_tb.sv
module corectl_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NREG = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [1:0]  core_req;
    logic [3:0]  core_op;
    logic [1:0]  core_done = '0;
    logic [31:0] boot_entry, boot_arg;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    corectl_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .core_req(core_req), .core_op(core_op), .core_done(core_done),
        .boot_entry(boot_entry), .boot_arg(boot_arg)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic pulse_done(input logic [1:0] m);
        @(negedge clk);
        core_done = m;
        @(negedge clk);
        core_done = '0;
    endtask

    // called right after the request cycle: request must have dropped
    task automatic done_after_one(input logic [1:0] m);
        @(negedge clk);
        check("R11 single-cycle request", {30'h0, core_req}, 32'h0);
        core_done = m;
        @(negedge clk);
        core_done = '0;
    endtask

    function automatic logic [31:0] init_val(input int i);
        return (i == 0) ? 32'hA0 : (i == 7) ? 32'h1 : (i == 9) ? 32'h1F : 32'h0;
    endfunction

    function automatic logic [31:0] pat(input int i);
        return (32'(i) + 32'd1) * 32'h0101_0103 ^ 32'h5A5A_0000;
    endfunction

    task automatic finish_up();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_up();
    end

    initial begin
        logic [31:0] v;
        logic [31:0] hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values
        for (int i = 0; i < NREG; i++) begin
            rd(12'(i*4), v);
            check("R1 reset value", v, init_val(i));
        end
        check("R1 no request", {30'h0, core_req}, 32'h0);

        // R2: plain storage sweep (side-effect registers skipped)
        for (int i = 0; i < NREG; i++) begin
            if (i != 1 && i != 2) wr(12'(i*4), pat(i));
        end
        for (int i = 0; i < NREG; i++) begin
            if (i != 1 && i != 2) begin
                rd(12'(i*4), v);
                check("R2 readback", v, pat(i));
            end
        end

        // R3: out-of-range window
        wr(12'h050, 32'hFFFF_FFFF);
        wr(12'hFFC, 32'hDEAD_BEEF);
        rd(12'h050, v); check("R3 oob read 0x50", v, 32'h0);
        rd(12'hFFC, v); check("R3 oob read 0xFFC", v, 32'h0);
        rd(12'h800, v); check("R3 oob read 0x800", v, 32'h0);
        for (int i = 0; i < NREG; i++) begin
            if (i != 1 && i != 2) begin
                rd(12'(i*4), v);
                check("R3 oob write ignored", v, pat(i));
            end
        end

        // R4/R5: sweep reset-bit patterns
        hi = 32'hABC0_0000;
        for (int n = 1; n < 4; n++) begin
            wr(12'h004, hi | 32'(n));
            check("R4 request mask", {30'h0, core_req}, 32'(n));
            check("R4 core0 op", {30'h0, core_op[1:0]}, (n & 1) ? 32'd1 : 32'd0);
            check("R4 core1 op", {30'h0, core_op[3:2]}, (n & 2) ? 32'd1 : 32'd0);
            rd(12'h004, v);
            check("R5 bits held before done", v, hi | 32'(n));
            done_after_one(2'(n));
            rd(12'h004, v);
            check("R5 bits cleared on done", v, hi);
            check("R9 nothing held", {30'h0, core_req}, 32'h0);
        end
        wr(12'h004, hi);
        check("R4 unchanged bits no request", {30'h0, core_req}, 32'h0);

        // R6/R8/R9: start with held reset
        wr(12'h030, 32'h8000_1000);
        wr(12'h034, 32'h0000_1234);
        wr(12'h008, 32'h2);
        check("R6 start request", {30'h0, core_req}, 32'h2);
        check("R6 start op", {30'h0, core_op[3:2]}, 32'd2);
        check("R6 entry", boot_entry, 32'h8000_1000);
        check("R6 arg", boot_arg, 32'h0000_1234);
        wr(12'h004, hi | 32'h2);
        check("R9 held while busy", {30'h0, core_req}, 32'h0);
        rd(12'h004, v); check("R5 stored write", v, hi | 32'h2);
        pulse_done(2'b10);
        rd(12'h004, v); check("R8 start done clears core1 bit", v, hi);
        check("R9 held issued after done", {30'h0, core_req}, 32'h2);
        check("R9 held op reset", {30'h0, core_op[3:2]}, 32'd1);
        done_after_one(2'b10);
        check("R9 no extra request", {30'h0, core_req}, 32'h0);

        // R7: power-off
        wr(12'h008, 32'h0);
        check("R7 off request", {30'h0, core_req}, 32'h2);
        check("R7 off op", {30'h0, core_op[3:2]}, 32'd3);
        done_after_one(2'b10);
        wr(12'h008, 32'h100);
        check("R6 unchanged enable no request", {30'h0, core_req}, 32'h0);
        rd(12'h008, v); check("R6 enable reg stored", v, 32'h100);
        rd(12'h030, v); check("R2 entry reg intact", v, 32'h8000_1000);

        // R10: done on the wrong core and while idle
        pulse_done(2'b11);
        rd(12'h004, v); check("R10 idle done no effect", v, hi);
        check("R10 idle done no request", {30'h0, core_req}, 32'h0);
        wr(12'h004, hi | 32'h2);
        pulse_done(2'b01);
        rd(12'h004, v); check("R10 other core done ignored", v, hi | 32'h2);
        check("R10 no spurious request", {30'h0, core_req}, 32'h0);
        pulse_done(2'b10);
        rd(12'h004, v); check("R5 core1 cleared", v, hi);

        // R9: only the newest held trigger survives
        wr(12'h004, hi | 32'h1);
        check("R4 core0 request", {30'h0, core_req}, 32'h1);
        wr(12'h004, hi);
        wr(12'h004, hi | 32'h1);
        check("R9 held twice no issue", {30'h0, core_req}, 32'h0);
        pulse_done(2'b01);
        check("R9 single relaunch", {30'h0, core_req}, 32'h1);
        rd(12'h004, v); check("R5 write beats later clear", v, hi);
        done_after_one(2'b01);
        check("R9 one relaunch only", {30'h0, core_req}, 32'h0);

        wr(12'h008, 32'h2);
        check("R6 start again", {30'h0, core_op[3:2]}, 32'd2);
        wr(12'h008, 32'h0);
        wr(12'h008, 32'h2);
        pulse_done(2'b10);
        check("R9 newest held kind", {30'h0, core_op[3:2]}, 32'd2);
        done_after_one(2'b10);
        check("R9 idle after", {30'h0, core_req}, 32'h0);

        finish_up();
    end

endmodule